// File: doc/BRIEF.md
# Programmable Pulse-Per-Second Event Delay

This block shifts a single-cycle pulse-per-second event later in time by a programmable number of clock cycles. Its input is the one-cycle strobe that marks each rising edge of an already synchronized external timing pin. Its output is that same one-cycle strobe, moved later by the configured number of cycles. The output feeds both a pulse-interval counter and the system timing output, so both see the same shifted timing.

The delay is a 32-bit count of whole clock cycles (one cycle is 5 ns at 200 MHz). The value arrives already moved into this clock domain by a register crossing, so it may change at any moment. The block therefore latches it when it accepts an event. Delays can span more than a full pulse period, so a loadable down-counter holds the pending pulse instead of a shift line. A delay of zero is a pure bypass with no added latency.

Top module: `pps_event_delay`

## Requirements
- R1: A synchronous active-high reset clears any pending pulse and holds `evt_out` low. After reset the output stays low until a new input event arrives, and the delay defaults to zero from the outside.
- R2: With `delay_cycles` equal to 0 when `evt_in` is high, `evt_out` is high in that same cycle (combinational bypass), and no later pulse follows for that event.
- R3: With `delay_cycles` equal to N ≥ 1 when `evt_in` is high in cycle t, `evt_out` is high in cycle t+N only, for exactly one cycle.
- R4: The delay is latched in the cycle the event is accepted. A change of `delay_cycles` while a pulse is pending does not move that pulse.
- R5: An input event that arrives while a pulse is pending cancels the pending pulse, including one that would come due in that very cycle. Timing restarts from the new event with the delay present in its cycle.
- R6: `evt_out` is never high in a cycle with no input event (bypass) and no due pending pulse, so each input event produces at most one output pulse.
- R7: The full 32-bit delay range is counted, so a delay much longer than the short test values (hundreds of cycles) lands on its exact cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Single-cycle event from the synchronized timing pin |
| delay_cycles | input | 32 | Requested delay in clock cycles, already in this clock domain |
| evt_out | output | 1 | Delayed single-cycle event |

## Verification
On every cycle the assertions check the counter's load value after an accepted event, its one-per-cycle count-down, the clearing of the pending flag after it fires or on reset, and that no output appears without a bypassed event or a due pending pulse. The exact landing cycle for each delay, immunity to delay changes mid-flight, and the cancel-and-restart behaviour of a second event, including the same-cycle collision, are shown only by the bench's directed scenarios. These scenarios compare each output against positions computed from the requirements.

// File: rtl/pps_dly_pkg.sv
package pps_dly_pkg;

    localparam int DLY_W = 32;

    typedef logic [DLY_W-1:0] dly_t;

    // State of the single pending delayed pulse.
    typedef struct packed {
        logic pending;
        dly_t remaining;   // cycles still to wait after the current one
    } hold_t;

    // Load command from the acceptance stage to the counter.
    typedef struct packed {
        logic arm;         // start a new delayed pulse
        logic cancel;      // drop whatever is pending
        dly_t load;
    } load_cmd_t;

    function automatic logic is_bypass(input dly_t d);
        return (d == '0);
    endfunction

    function automatic logic is_due(input hold_t h);
        return h.pending && (h.remaining == '0);
    endfunction

endpackage

// File: rtl/pps_dly_accept.sv
module pps_dly_accept
    import pps_dly_pkg::*;
(
    input  logic      evt_in,
    input  dly_t      delay_cycles,
    output load_cmd_t cmd
);
    always_comb begin
        cmd.cancel = evt_in;
        cmd.arm    = evt_in && !is_bypass(delay_cycles);
        cmd.load   = delay_cycles - dly_t'(1);
    end
endmodule

// File: rtl/pps_dly_counter.sv
module pps_dly_counter
    import pps_dly_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  load_cmd_t cmd,
    input  dly_t      delay_cycles,
    output hold_t     hold
);
    hold_t hold_nx;

    always_comb begin
        hold_nx = hold;
        if (cmd.cancel) begin
            hold_nx.pending   = cmd.arm;
            hold_nx.remaining = cmd.arm ? cmd.load : '0;
        end else if (hold.pending) begin
            if (hold.remaining == '0) begin
                hold_nx.pending = 1'b0;
            end else begin
                hold_nx.remaining = hold.remaining - dly_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else begin
            hold <= hold_nx;
        end
    end

    // R4/R5: an accepted nonzero delay loads delay-1
    assert_load_value_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.cancel && delay_cycles != '0) |=>
            (hold.pending && hold.remaining == $past(delay_cycles) - dly_t'(1)));

    // R3: count-down by exactly one per cycle while waiting
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.cancel && hold.pending && hold.remaining != '0) |=>
            (hold.pending && hold.remaining == $past(hold.remaining) - dly_t'(1)));

    // R3: the pulse fires once, then the hold empties
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.cancel && hold.pending && hold.remaining == '0) |=> !hold.pending);

    // R1: reset clears the pending pulse
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !hold.pending);
endmodule

// File: rtl/pps_dly_emit.sv
module pps_dly_emit
    import pps_dly_pkg::*;
(
    input  logic  evt_in,
    input  dly_t  delay_cycles,
    input  hold_t hold,
    output logic  evt_out
);
    // A new event overrides any pulse that is due in the same cycle.
    always_comb begin
        if (evt_in) begin
            evt_out = is_bypass(delay_cycles);
        end else begin
            evt_out = is_due(hold);
        end
    end
endmodule

// File: rtl/pps_event_delay.sv
module pps_event_delay
    import pps_dly_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_in,
    input  logic [31:0] delay_cycles,
    output logic        evt_out
);
    load_cmd_t cmd;
    hold_t     hold;

    pps_dly_accept accept_i (
        .evt_in       (evt_in),
        .delay_cycles (delay_cycles),
        .cmd          (cmd)
    );

    pps_dly_counter counter_i (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .delay_cycles (delay_cycles),
        .hold         (hold)
    );

    pps_dly_emit emit_i (
        .evt_in       (evt_in),
        .delay_cycles (delay_cycles),
        .hold         (hold),
        .evt_out      (evt_out)
    );

    // R6: no output without an event or a pending pulse
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt_in && !hold.pending) |-> !evt_out);

    // R2: a zero-delay event leaves nothing pending
    assert_bypass_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_in && delay_cycles == '0) |=> !hold.pending);
endmodule

// File: tb/pps_event_delay_tb.sv
module pps_event_delay_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_in = 1'b0;
    logic [31:0] delay_cycles = '0;
    logic        evt_out;

    int checks = 0;
    int errors = 0;
    int pos [4];
    int npos;

    always #5 clk = ~clk;

    pps_event_delay dut_i (
        .clk          (clk),
        .rst          (rst),
        .evt_in       (evt_in),
        .delay_cycles (delay_cycles),
        .evt_out      (evt_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive event A at cycle 0 with delay da; optional event B at cycle cb
    // with delay db; optional delay change to vc from cycle cc; optional
    // reset in cycle cr. Records cycles where evt_out is high.
    task automatic run_seq(input int da, input int cb, input int db,
                           input int cc, input int vc, input int cr,
                           input int win);
        npos = 0;
        for (int k = 0; k <= win; k++) begin
            @(negedge clk);
            evt_in = (k == 0) || (k == cb);
            if (k == 0) delay_cycles = 32'(da);
            else if (k == cb) delay_cycles = 32'(db);
            else if (cc >= 0 && k >= cc) delay_cycles = 32'(vc);
            rst = (k == cr);
            #1;
            if (evt_out) begin
                if (npos < 4) pos[npos] = k;
                npos++;
            end
        end
        @(negedge clk);
        evt_in = 1'b0;
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R1 output low in reset", int'(evt_out), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #1 check("R1 output low after reset", int'(evt_out), 0);
    endtask

    task automatic t_bypass;
        run_seq(0, -1, 0, -1, 0, -1, 8);
        check("R2 pulse count", npos, 1);
        check("R2 same cycle", pos[0], 0);
    endtask

    task automatic t_delay(input int d, input string req);
        run_seq(d, -1, 0, -1, 0, -1, d + 6);
        check({req, " pulse count"}, npos, 1);
        check({req, " landing cycle"}, pos[0], d);
    endtask

    task automatic t_change_midflight;
        run_seq(9, -1, 0, 3, 2, -1, 20);
        check("R4 pulse count", npos, 1);
        check("R4 landing unchanged", pos[0], 9);
    endtask

    task automatic t_retrigger;
        run_seq(10, 4, 10, -1, 0, -1, 25);
        check("R5 retrigger count", npos, 1);
        check("R5 retrigger landing", pos[0], 14);
    endtask

    task automatic t_collision;
        run_seq(5, 5, 3, -1, 0, -1, 14);
        check("R5 collision count", npos, 1);
        check("R5 collision landing", pos[0], 8);
    endtask

    task automatic t_reset_pending;
        run_seq(6, -1, 0, -1, 0, 2, 12);
        check("R1 reset cancels pending", npos, 0);
        delay_cycles = '0;
    endtask

    task automatic t_quiet;
        int seen = 0;
        delay_cycles = '0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            #1 if (evt_out) seen++;
        end
        check("R6 no output without events", seen, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_bypass();
        t_delay(1, "R3 delay 1");
        t_delay(2, "R3 delay 2");
        t_delay(37, "R3 delay 37");
        t_delay(700, "R7 delay 700");
        t_change_midflight();
        t_retrigger();
        t_collision();
        t_reset_pending();
        t_quiet();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule